// File: doc/BRIEF.md
# Control-Flow and Condition Unit

This block resolves the program counter that follows each instruction of a 32-bit, 16-register processor. It takes the instruction word, the current PC, the zero and negative flags, and three register values that the register file reads for it: the subroutine link (r15), the interrupt link (r14) and the register named by an indirect jump. Each cycle it returns the next PC, whether control left the sequential path, and an optional write of a link register. The output paths are combinational. The pipeline sequences them around the block.

The block also owns the control part of the condition register. This part is the interrupt-active bit, the halt bit and the three-bit halt reason. A software interrupt sets the interrupt-active bit and a return from interrupt clears it. A trap opcode halts the core. While the core is halted, every instruction is ignored and the PC stays where it is until reset.

The instruction fields are positional. The opcode sits in bits 31:24, the jump offset in bits 23:0, and the secondary function code in bits 11:0.

Top module: `flow_ctl_unit`

## Requirements
- R1: After reset is asserted (rst_n low), irq_active, halted and halt_reason are all 0.
- R2: A valid instruction that is not a flow instruction gives next_pc = cur_pc + 4, taken = 0 and link_we = 0. This covers every opcode other than 0x00, 0x10 to 0x16, 0x20 and 0x21. It also covers opcode 0x01 with a function code other than 0x000 or 0x001.
- R3: The conditional opcodes are decided as follows:
  - 0x10 jumps when Z = 1.
  - 0x11 jumps when Z = 0.
  - 0x12 jumps when Z = 0 and N = 0.
  - 0x13 jumps when N = 1.
  - 0x14 jumps when Z = 1 or N = 1.
  - 0x15 jumps when Z = 1 or N = 0.
  - When the condition fails, the instruction behaves as in R2.
- R4: A taken relative jump gives next_pc = cur_pc + the sign-extended instr[23:0], computed modulo 2^32, and taken = 1.
- R5: Opcode 0x16 always jumps relative. It asserts link_we with link_idx = 15 and link_data = cur_pc.
- R6: Opcode 0x01 with function 0x000 gives next_pc = ret_addr. Opcode 0x01 with function 0x001 gives next_pc = ind_addr. Both assert taken = 1 and link_we = 0.
- R7: Opcode 0x20 jumps relative. It asserts link_we with link_idx = 14 and link_data = cur_pc, and irq_active reads 1 after the next clock edge.
- R8: Opcode 0x21 gives next_pc = irq_addr with taken = 1 and link_we = 0, and irq_active reads 0 after the next clock edge.
- R9: Opcode 0x00 gives next_pc = cur_pc, taken = 0 and link_we = 0. After the next clock edge, halted = 1 and halt_reason = 3'b001.
- R10: While halted = 1, any instruction gives next_pc = cur_pc, taken = 0 and link_we = 0. The instruction changes neither irq_active nor the halt state. This holds until reset.
- R11: With instr_valid = 0, the outputs are next_pc = cur_pc, taken = 0 and link_we = 0, and no state bit changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_valid | input | 1 | Instruction word is live this cycle |
| instr | input | 32 | Instruction word |
| cur_pc | input | 32 | Address of the instruction |
| flag_z | input | 1 | Zero flag |
| flag_n | input | 1 | Negative flag |
| ret_addr | input | 32 | Value of r15 |
| irq_addr | input | 32 | Value of r14 |
| ind_addr | input | 32 | Value of the register selected by an indirect jump |
| next_pc | output | 32 | Resolved next PC |
| taken | output | 1 | Control left the sequential path |
| link_we | output | 1 | Link register write request |
| link_idx | output | 4 | Index of the register to write |
| link_data | output | 32 | Data for the link write |
| irq_active | output | 1 | Interrupt-active bit |
| halted | output | 1 | Halt bit |
| halt_reason | output | 3 | Halt reason code |

## Verification
A software interrupt does two things in one cycle. It redirects the PC relative to itself and writes the interrupt link register. Then, on the same clock edge, it sets the interrupt-active bit. The bench issues that opcode and judges all three effects: the target and the link index/data in the issuing cycle, and the state bit after the edge.

The second collision is between a trap and the halt freeze. The bench applies a trap and then presents a software interrupt on the very next cycle. It expects the interrupt to be discarded, with the PC frozen, no link write and the interrupt-active bit unchanged.

// File: rtl/flow_pkg.sv
package flow_pkg;

   typedef enum logic [7:0] {
      OP_TRAP  = 8'h00,
      OP_REGOP = 8'h01,
      OP_JEQ   = 8'h10,
      OP_JNE   = 8'h11,
      OP_JGT   = 8'h12,
      OP_JLT   = 8'h13,
      OP_JLE   = 8'h14,
      OP_JGE   = 8'h15,
      OP_JAL   = 8'h16,
      OP_SWI   = 8'h20,
      OP_RTI   = 8'h21
   } flow_op_e;

   localparam logic [11:0] FN_RET  = 12'h000;
   localparam logic [11:0] FN_JREG = 12'h001;

   typedef enum logic [2:0] {
      SRC_SEQ,
      SRC_REL,
      SRC_RET,
      SRC_IND,
      SRC_IRQ,
      SRC_HOLD
   } pc_src_e;

   typedef struct packed {
      pc_src_e src;
      logic    link_sub;
      logic    link_irq;
      logic    set_irq;
      logic    clr_irq;
      logic    trap;
   } flow_dec_t;

endpackage

// File: rtl/flow_cond_eval.sv
module flow_cond_eval
   import flow_pkg::*;
#(
   parameter int OP_W = 8
) (
   input  logic [OP_W-1:0] opcode,
   input  logic            flag_z,
   input  logic            flag_n,
   output logic            is_cond,
   output logic            hit
);

   always_comb begin
      is_cond = 1'b1;
      hit     = 1'b0;
      case (opcode)
         OP_JEQ:  hit = flag_z;
         OP_JNE:  hit = !flag_z;
         OP_JGT:  hit = !flag_z && !flag_n;
         OP_JLT:  hit = flag_n;
         OP_JLE:  hit = flag_z || flag_n;
         OP_JGE:  hit = flag_z || !flag_n;
         default: is_cond = 1'b0;
      endcase
   end

endmodule

// File: rtl/flow_decode.sv
module flow_decode
   import flow_pkg::*;
#(
   parameter int OP_W = 8,
   parameter int FN_W = 12
) (
   input  logic            instr_valid,
   input  logic            halted,
   input  logic [OP_W-1:0] opcode,
   input  logic [FN_W-1:0] func,
   input  logic            flag_z,
   input  logic            flag_n,
   output flow_dec_t       dec
);

   logic cond_is;
   logic cond_hit;

   flow_cond_eval #(.OP_W(OP_W)) u_cond (
      .opcode  (opcode),
      .flag_z  (flag_z),
      .flag_n  (flag_n),
      .is_cond (cond_is),
      .hit     (cond_hit)
   );

   always_comb begin
      dec.src      = SRC_SEQ;
      dec.link_sub = 1'b0;
      dec.link_irq = 1'b0;
      dec.set_irq  = 1'b0;
      dec.clr_irq  = 1'b0;
      dec.trap     = 1'b0;
      if (!instr_valid || halted) begin
         dec.src = SRC_HOLD;
      end else begin
         case (opcode)
            OP_TRAP: begin
               dec.src  = SRC_HOLD;
               dec.trap = 1'b1;
            end
            OP_REGOP: begin
               if (func == FN_RET)       dec.src = SRC_RET;
               else if (func == FN_JREG) dec.src = SRC_IND;
            end
            OP_JAL: begin
               dec.src      = SRC_REL;
               dec.link_sub = 1'b1;
            end
            OP_SWI: begin
               dec.src      = SRC_REL;
               dec.link_irq = 1'b1;
               dec.set_irq  = 1'b1;
            end
            OP_RTI: begin
               dec.src     = SRC_IRQ;
               dec.clr_irq = 1'b1;
            end
            default: begin
               if (cond_is && cond_hit) dec.src = SRC_REL;
            end
         endcase
      end
   end

endmodule

// File: rtl/flow_target.sv
module flow_target
   import flow_pkg::*;
#(
   parameter int XLEN            = 32,
   parameter int OFS_W           = 24,
   parameter int PC_STEP         = 4,
   parameter bit OFFSET_IN_WORDS = 1'b0
) (
   input  pc_src_e          src,
   input  logic [XLEN-1:0]  cur_pc,
   input  logic [OFS_W-1:0] offset,
   input  logic [XLEN-1:0]  ret_addr,
   input  logic [XLEN-1:0]  irq_addr,
   input  logic [XLEN-1:0]  ind_addr,
   output logic [XLEN-1:0]  next_pc
);

   localparam int EXT_W = XLEN - OFS_W;

   logic [XLEN-1:0] ofs_ext;
   logic [XLEN-1:0] ofs_scaled;
   logic [XLEN-1:0] rel_pc;
   logic [XLEN-1:0] seq_pc;

   assign ofs_ext = {{EXT_W{offset[OFS_W-1]}}, offset};

   generate
      if (OFFSET_IN_WORDS) begin : g_word_ofs
         assign ofs_scaled = ofs_ext << $clog2(PC_STEP);
      end else begin : g_byte_ofs
         assign ofs_scaled = ofs_ext;
      end
   endgenerate

   assign rel_pc = cur_pc + ofs_scaled;
   assign seq_pc = cur_pc + XLEN'(PC_STEP);

   always_comb begin
      case (src)
         SRC_REL:  next_pc = rel_pc;
         SRC_RET:  next_pc = ret_addr;
         SRC_IND:  next_pc = ind_addr;
         SRC_IRQ:  next_pc = irq_addr;
         SRC_HOLD: next_pc = cur_pc;
         default:  next_pc = seq_pc;
      endcase
   end

endmodule

// File: rtl/flow_state.sv
module flow_state #(
   parameter int          RSN_W     = 3,
   parameter logic [RSN_W-1:0] TRAP_CODE = 3'b001
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_irq,
   input  logic             clr_irq,
   input  logic             trap,
   output logic             irq_active,
   output logic             halted,
   output logic [RSN_W-1:0] halt_reason
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_active  <= 1'b0;
         halted      <= 1'b0;
         halt_reason <= '0;
      end else begin
         if (set_irq)      irq_active <= 1'b1;
         else if (clr_irq) irq_active <= 1'b0;
         if (trap) begin
            halted      <= 1'b1;
            halt_reason <= TRAP_CODE;
         end
      end
   end

endmodule

// File: rtl/flow_ctl_unit.sv
module flow_ctl_unit
   import flow_pkg::*;
#(
   parameter int XLEN            = 32,
   parameter int OP_W            = 8,
   parameter int OFS_W           = 24,
   parameter int FN_W            = 12,
   parameter int RIDX_W          = 4,
   parameter int RSN_W           = 3,
   parameter int PC_STEP         = 4,
   parameter bit OFFSET_IN_WORDS = 1'b0,
   parameter int SUB_LINK_REG    = 15,
   parameter int IRQ_LINK_REG    = 14,
   parameter logic [RSN_W-1:0] TRAP_CODE = 3'b001
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              instr_valid,
   input  logic [XLEN-1:0]   instr,
   input  logic [XLEN-1:0]   cur_pc,
   input  logic              flag_z,
   input  logic              flag_n,
   input  logic [XLEN-1:0]   ret_addr,
   input  logic [XLEN-1:0]   irq_addr,
   input  logic [XLEN-1:0]   ind_addr,
   output logic [XLEN-1:0]   next_pc,
   output logic              taken,
   output logic              link_we,
   output logic [RIDX_W-1:0] link_idx,
   output logic [XLEN-1:0]   link_data,
   output logic              irq_active,
   output logic              halted,
   output logic [RSN_W-1:0]  halt_reason
);

   localparam int NREGS = 1 << RIDX_W;

   generate
      if (OP_W + OFS_W != XLEN) begin : g_chk_fields
         $error("opcode and offset fields must fill the instruction word");
      end
      if (OP_W != 8) begin : g_chk_op
         $error("opcode width must match the opcode enumeration");
      end
      if (FN_W > OFS_W) begin : g_chk_fn
         $error("function field must lie inside the offset field");
      end
      if (SUB_LINK_REG >= NREGS || IRQ_LINK_REG >= NREGS) begin : g_chk_link
         $error("link register index out of range");
      end
      if ((PC_STEP & (PC_STEP - 1)) != 0) begin : g_chk_step
         $error("PC step must be a power of two");
      end
   endgenerate

   logic [OP_W-1:0]  opcode;
   logic [OFS_W-1:0] offset;
   logic [FN_W-1:0]  func;
   flow_dec_t        dec;

   assign opcode = instr[XLEN-1 -: OP_W];
   assign offset = instr[OFS_W-1:0];
   assign func   = instr[FN_W-1:0];

   flow_decode #(.OP_W(OP_W), .FN_W(FN_W)) u_dec (
      .instr_valid (instr_valid),
      .halted      (halted),
      .opcode      (opcode),
      .func        (func),
      .flag_z      (flag_z),
      .flag_n      (flag_n),
      .dec         (dec)
   );

   flow_target #(
      .XLEN            (XLEN),
      .OFS_W           (OFS_W),
      .PC_STEP         (PC_STEP),
      .OFFSET_IN_WORDS (OFFSET_IN_WORDS)
   ) u_tgt (
      .src      (dec.src),
      .cur_pc   (cur_pc),
      .offset   (offset),
      .ret_addr (ret_addr),
      .irq_addr (irq_addr),
      .ind_addr (ind_addr),
      .next_pc  (next_pc)
   );

   flow_state #(.RSN_W(RSN_W), .TRAP_CODE(TRAP_CODE)) u_state (
      .clk         (clk),
      .rst_n       (rst_n),
      .set_irq     (dec.set_irq),
      .clr_irq     (dec.clr_irq),
      .trap        (dec.trap),
      .irq_active  (irq_active),
      .halted      (halted),
      .halt_reason (halt_reason)
   );

   assign taken     = (dec.src == SRC_REL) || (dec.src == SRC_RET) ||
                      (dec.src == SRC_IND) || (dec.src == SRC_IRQ);
   assign link_we   = dec.link_sub || dec.link_irq;
   assign link_idx  = dec.link_sub ? RIDX_W'(SUB_LINK_REG) : RIDX_W'(IRQ_LINK_REG);
   assign link_data = cur_pc;

endmodule

// File: rtl/flow_ctl_checker.sv
module flow_ctl_checker #(
   parameter int XLEN    = 32,
   parameter int RIDX_W  = 4,
   parameter int RSN_W   = 3,
   parameter int PC_STEP = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              instr_valid,
   input logic [XLEN-1:0]   instr,
   input logic [XLEN-1:0]   cur_pc,
   input logic [XLEN-1:0]   irq_addr,
   input logic [XLEN-1:0]   next_pc,
   input logic              taken,
   input logic              link_we,
   input logic [RIDX_W-1:0] link_idx,
   input logic [XLEN-1:0]   link_data,
   input logic              irq_active,
   input logic              halted,
   input logic [RSN_W-1:0]  halt_reason
);

   logic [7:0] op;
   logic       live;
   assign op   = instr[XLEN-1 -: 8];
   assign live = instr_valid && !halted;

   assert_halt_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> halted);

   assert_halt_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
      halted |-> (next_pc == cur_pc && !taken && !link_we));

   assert_idle_freeze_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !instr_valid |-> (next_pc == cur_pc && !taken && !link_we));

   assert_trap_halts_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (live && op == 8'h00) |=> (halted && halt_reason == 3'b001));

   assert_swi_sets_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (live && op == 8'h20) |=> irq_active);

   assert_swi_link_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (live && op == 8'h20) |-> (link_we && link_idx == RIDX_W'(14) && link_data == cur_pc));

   assert_rti_clears_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (live && op == 8'h21) |=> !irq_active);

   assert_rti_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (live && op == 8'h21) |-> (next_pc == irq_addr && taken));

   assert_link_implies_taken_R5: assert property (@(posedge clk) disable iff (!rst_n)
      link_we |-> taken);

   assert_seq_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (live && !taken && op != 8'h00) |-> next_pc == cur_pc + XLEN'(PC_STEP));

   assert_irq_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!live) |=> $stable(irq_active));

endmodule

bind flow_ctl_unit flow_ctl_checker #(
   .XLEN    (XLEN),
   .RIDX_W  (RIDX_W),
   .RSN_W   (RSN_W),
   .PC_STEP (PC_STEP)
) u_flow_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .instr_valid (instr_valid),
   .instr       (instr),
   .cur_pc      (cur_pc),
   .irq_addr    (irq_addr),
   .next_pc     (next_pc),
   .taken       (taken),
   .link_we     (link_we),
   .link_idx    (link_idx),
   .link_data   (link_data),
   .irq_active  (irq_active),
   .halted      (halted),
   .halt_reason (halt_reason)
);

// File: tb/flow_ctl_unit_test.sv
`timescale 1ns/1ps
module flow_ctl_unit_test;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        instr_valid;
   logic [31:0] instr;
   logic [31:0] cur_pc;
   logic        flag_z;
   logic        flag_n;
   logic [31:0] ret_addr;
   logic [31:0] irq_addr;
   logic [31:0] ind_addr;
   logic [31:0] next_pc;
   logic        taken;
   logic        link_we;
   logic [3:0]  link_idx;
   logic [31:0] link_data;
   logic        irq_active;
   logic        halted;
   logic [2:0]  halt_reason;

   int n_vec  = 0;
   int n_miss = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   flow_ctl_unit uut (
      .clk (clk), .rst_n (rst_n), .instr_valid (instr_valid), .instr (instr),
      .cur_pc (cur_pc), .flag_z (flag_z), .flag_n (flag_n),
      .ret_addr (ret_addr), .irq_addr (irq_addr), .ind_addr (ind_addr),
      .next_pc (next_pc), .taken (taken), .link_we (link_we),
      .link_idx (link_idx), .link_data (link_data), .irq_active (irq_active),
      .halted (halted), .halt_reason (halt_reason)
   );

   // entry: instr, pc, z, n, expected next pc, expected taken
   localparam int NV = 22;
   localparam logic [98:0] VEC [NV] = '{
      {32'h10000010, 32'h00001000, 1'b1, 1'b0, 32'h00001010, 1'b1}, // R3 JEQ z
      {32'h10000010, 32'h00001000, 1'b0, 1'b0, 32'h00001004, 1'b0}, // R3 JEQ !z
      {32'h11000010, 32'h00001000, 1'b0, 1'b1, 32'h00001010, 1'b1}, // R3 JNE
      {32'h11000010, 32'h00001000, 1'b1, 1'b0, 32'h00001004, 1'b0},
      {32'h12FFFFF0, 32'h00001000, 1'b0, 1'b0, 32'h00000FF0, 1'b1}, // R3 R4 JGT back
      {32'h12FFFFF0, 32'h00001000, 1'b0, 1'b1, 32'h00001004, 1'b0},
      {32'h12FFFFF0, 32'h00001000, 1'b1, 1'b0, 32'h00001004, 1'b0},
      {32'h13000010, 32'h00001000, 1'b0, 1'b1, 32'h00001010, 1'b1}, // R3 JLT
      {32'h13000010, 32'h00001000, 1'b1, 1'b0, 32'h00001004, 1'b0},
      {32'h14000010, 32'h00001000, 1'b1, 1'b0, 32'h00001010, 1'b1}, // R3 JLE
      {32'h14000010, 32'h00001000, 1'b0, 1'b1, 32'h00001010, 1'b1},
      {32'h14000010, 32'h00001000, 1'b0, 1'b0, 32'h00001004, 1'b0},
      {32'h15000010, 32'h00001000, 1'b1, 1'b1, 32'h00001010, 1'b1}, // R3 JGE
      {32'h15000010, 32'h00001000, 1'b0, 1'b0, 32'h00001010, 1'b1},
      {32'h15000010, 32'h00001000, 1'b0, 1'b1, 32'h00001004, 1'b0},
      {32'h10800000, 32'h00000100, 1'b1, 1'b0, 32'hFF800100, 1'b1}, // R4 max negative
      {32'h107FFFFC, 32'hFFFFFFF0, 1'b1, 1'b0, 32'h007FFFEC, 1'b1}, // R4 wrap
      {32'h05000010, 32'h00001000, 1'b1, 1'b1, 32'h00001004, 1'b0}, // R2 imm op
      {32'h01000005, 32'h00002000, 1'b1, 1'b0, 32'h00002004, 1'b0}, // R2 reg op
      {32'h17000010, 32'h00002000, 1'b1, 1'b1, 32'h00002004, 1'b0}, // R2 unused
      {32'h01000000, 32'h00002000, 1'b0, 1'b0, 32'hAAAA0000, 1'b1}, // R6 return
      {32'h01000001, 32'h00002000, 1'b0, 1'b0, 32'h55550004, 1'b1}  // R6 indirect
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_miss++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
         $finish;
      end
   endtask

   task automatic drive(input logic v, input logic [31:0] w, input logic [31:0] pc);
      instr_valid = v;
      instr       = w;
      cur_pc      = pc;
   endtask

   initial begin
      #1_000_000;
      n_vec++;
      n_miss++;
      $display("FAIL watchdog actual=running expected=done");
      finish_run();
   end

   initial begin
      rst_n = 1'b0;
      drive(1'b0, 32'h0, 32'h0);
      flag_z = 1'b0; flag_n = 1'b0;
      ret_addr = 32'hAAAA0000; irq_addr = 32'h00003004; ind_addr = 32'h55550004;
      repeat (2) @(negedge clk);
      chk("R1 irq", {31'd0, irq_active}, 32'd0);
      chk("R1 halt", {31'd0, halted}, 32'd0);
      chk("R1 reason", {29'd0, halt_reason}, 32'd0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         drive(1'b1, VEC[i][98:67], VEC[i][66:35]);
         flag_z = VEC[i][34];
         flag_n = VEC[i][33];
         #1;
         chk($sformatf("R3/R4/R2/R6 vec%0d next", i), next_pc, VEC[i][32:1]);
         chk($sformatf("R3/R4/R2/R6 vec%0d taken", i), {31'd0, taken}, {31'd0, VEC[i][0]});
         chk($sformatf("R2 vec%0d link", i), {31'd0, link_we}, 32'd0);
      end

      // R5 jump and link
      @(negedge clk); drive(1'b1, 32'h16000020, 32'h00002000); #1;
      chk("R5 next", next_pc, 32'h00002020);
      chk("R5 link_we", {31'd0, link_we}, 32'd1);
      chk("R5 idx", {28'd0, link_idx}, 32'd15);
      chk("R5 data", link_data, 32'h00002000);

      // R7 software interrupt: target, link and state bit together
      @(negedge clk); drive(1'b1, 32'h20000040, 32'h00003000); #1;
      chk("R7 next", next_pc, 32'h00003040);
      chk("R7 taken", {31'd0, taken}, 32'd1);
      chk("R7 idx", {28'd0, link_idx}, 32'd14);
      chk("R7 data", link_data, 32'h00003000);
      chk("R7 link_we", {31'd0, link_we}, 32'd1);
      @(negedge clk); drive(1'b0, 32'h0, 32'h00003040); #1;
      chk("R7 irq set", {31'd0, irq_active}, 32'd1);

      // R11 invalid slot carrying a return from interrupt
      @(negedge clk); drive(1'b0, 32'h21000000, 32'h00003040); #1;
      chk("R11 next", next_pc, 32'h00003040);
      chk("R11 taken", {31'd0, taken}, 32'd0);
      @(negedge clk); drive(1'b0, 32'h0, 32'h00003040); #1;
      chk("R11 irq kept", {31'd0, irq_active}, 32'd1);

      // R8 return from interrupt
      @(negedge clk); drive(1'b1, 32'h21000000, 32'h00003040); #1;
      chk("R8 next", next_pc, 32'h00003004);
      chk("R8 taken", {31'd0, taken}, 32'd1);
      chk("R8 link_we", {31'd0, link_we}, 32'd0);
      @(negedge clk); drive(1'b0, 32'h0, 32'h00003004); #1;
      chk("R8 irq cleared", {31'd0, irq_active}, 32'd0);

      // R9 trap
      @(negedge clk); drive(1'b1, 32'h00000000, 32'h00004000); #1;
      chk("R9 next", next_pc, 32'h00004000);
      chk("R9 taken", {31'd0, taken}, 32'd0);

      // R10 software interrupt right after the trap is discarded
      @(negedge clk); drive(1'b1, 32'h20000040, 32'h00004000); #1;
      chk("R9 halted", {31'd0, halted}, 32'd1);
      chk("R9 reason", {29'd0, halt_reason}, 32'd1);
      chk("R10 next", next_pc, 32'h00004000);
      chk("R10 taken", {31'd0, taken}, 32'd0);
      chk("R10 link_we", {31'd0, link_we}, 32'd0);
      @(negedge clk); drive(1'b1, 32'h16000020, 32'h00004000); #1;
      chk("R10 irq untouched", {31'd0, irq_active}, 32'd0);
      chk("R10 jal frozen", next_pc, 32'h00004000);
      chk("R10 still halted", {31'd0, halted}, 32'd1);

      // R1 reset clears the halt
      @(negedge clk); rst_n = 1'b0; drive(1'b0, 32'h0, 32'h0); #1;
      chk("R1 halt cleared", {31'd0, halted}, 32'd0);
      chk("R1 reason cleared", {29'd0, halt_reason}, 32'd0);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      finish_run();
   end

endmodule